// File: doc/BRIEF.md
# Associative Translation Lookup with Fault Capture

This block translates one virtual address at a time against a fully associative set of translation entries. Each entry is a pair of 64-bit words, a tag word and a translation word. A separate fill block writes them and presents them to this block as two flat buses. A request carries a virtual address, the current 13-bit context and two flags: user mode and write access. After a fixed latency the block reports exactly one outcome. A hit returns a physical address and a write-permission flag. A fault means a matching entry refused the access; it updates a fault status register and, on the data side, a fault address register. A miss means no entry matched; it loads a tag access register with the page address and context, for use by a later refill.

A three-state controller sequences each request:
- IDLE goes to LOOKUP when `req_valid` is high, and the request is captured.
- LOOKUP always goes to RESOLVE. In LOOKUP, every entry is compared in parallel and the winning entry's fields are registered.
- RESOLVE always goes back to IDLE. In RESOLVE, the outcome is decided, the pulse and registers are written, and the controller returns to IDLE.

The parameter `IS_DATA` picks the variant. The data side checks both privilege and write permission. The instruction side checks privilege only.

Top module: `tlb_xlate_lookup`

## Requirements
- R1: After reset, `hit`, `miss`, `fault`, `wr_ok` and `busy` are 0, and `pa`, `fault_status`, `fault_addr` and `tag_access` are all zero.
- R2: An entry matches only when all three of these hold:
  - its translation word bit 63 (valid) is 1;
  - its tag bits 12:0 equal the request context;
  - its tag equals the virtual address on every bit covered by the page mask.
  The outcome pulse appears on the second rising edge after the edge that accepted the request.
- R3: Translation word bits 62:61 hold a size code n (0 to 3). The page mask covers address bits 63 down to 13+3n, so the page sizes are 8 KiB, 64 KiB, 512 KiB and 4 MiB.
- R4: On a hit, `pa` bits 40:13 come from the translation word above the page offset and from the virtual address inside it. `pa` bits 12:0 are zero. On a miss or fault, `pa` becomes zero.
- R5: When several entries match, the one with the lowest index supplies the result.
- R6: A matching entry whose translation bit 2 (privileged) is 1 faults when `req_user` is 1, and no hit is reported.
- R7: Data variant only: a matching entry whose translation bit 1 (writable) is 0 faults on a write. On a hit, `wr_ok` equals translation bit 1.
- R8: A data fault writes these status bits, and writes the faulting virtual address to `fault_addr`:

  | Bit | Value |
  |-----|-------|
  | 0 | 1 |
  | 2 | write flag |
  | 3 | user flag |
  | 7 | 1 when the privileged check failed |

- R9: If status bit 0 is already 1 when a fault arrives, the status is first replaced by the value 2 (overflow), and then the new fields of R8 are merged in.
- R10: On a miss, `tag_access` becomes the virtual address bits 63:13 with the context in bits 12:0, and the fault status is left unchanged.
- R11: A cycle with `stat_clr` high zeroes `fault_status` and `fault_addr`, unless a fault is recorded in that same cycle.
- R12: `hit`, `miss` and `fault` are one-cycle pulses, and at most one is high at a time. `busy` is high from acceptance until the outcome. A request presented while `busy` is high is ignored.
- R13: Instruction variant: only the privileged check applies. A status update sets bits 0 and 3 only (plus overflow), and `fault_addr` is never written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Current context |
| req_user | input | 1 | 1 for a user-mode access |
| req_write | input | 1 | 1 for a write access |
| stat_clr | input | 1 | Clears fault status and fault address |
| tag_words | input | ENTRIES*64 | Tag words, entry i at bits i*64 upward |
| tte_words | input | ENTRIES*64 | Translation words, entry i at bits i*64 upward |
| busy | output | 1 | A request is in flight |
| hit | output | 1 | Translation succeeded (pulse) |
| miss | output | 1 | No entry matched (pulse) |
| fault | output | 1 | Protection violation (pulse) |
| pa | output | 41 | Physical address of the last outcome |
| wr_ok | output | 1 | Page of the last hit is writable |
| fault_status | output | 16 | Fault status register |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Page address and context of the last miss |

## Verification
A request is accepted on one rising edge, its entry choice is registered on the next edge, and its outcome is registered on the edge after that. The pulses, `pa`, `wr_ok` and the three registers are therefore due two edges after acceptance. `busy` changes on the acceptance edge itself.

The bench runs a behavioural reference that advances on every rising edge with the same two-edge schedule. It compares all outputs at each falling edge, so a value that is one cycle early or late is reported. The directed checks sample at the falling edge that follows the outcome edge. The bench does not change the entry buses while a request is in flight.

// File: rtl/tlb_xl_pkg.sv
package tlb_xl_pkg;

    localparam int WORD_W      = 64;
    localparam int CTX_W       = 13;
    localparam int PAGE_SHIFT  = 13;
    localparam int SIZE_STEP   = 3;

    // translation word bit positions
    localparam int VLD_BIT     = 63;
    localparam int SZ_MSB      = 62;
    localparam int SZ_LSB      = 61;
    localparam int PRIV_BIT    = 2;
    localparam int WRT_BIT     = 1;

    // fault status layout
    localparam int ST_WR_BIT   = 2;
    localparam int ST_USER_BIT = 3;
    localparam int ST_TYPE_LSB = 7;
    localparam int OVF_CODE    = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOOKUP  = 2'd1,
        ST_RESOLVE = 2'd2
    } tlb_state_e;

    // address bits that take part in the page compare for a size code
    function automatic logic [WORD_W-1:PAGE_SHIFT] page_mask(input logic [1:0] code);
        logic [WORD_W-1:PAGE_SHIFT] m;
        m = '1;
        return m << (SIZE_STEP * int'(code));
    endfunction

endpackage

// File: rtl/tlb_xl_entry_cmp.sv
module tlb_xl_entry_cmp
    import tlb_xl_pkg::*;
#(
    parameter int PA_MSB = 40,
    localparam int PFN_W = PA_MSB - PAGE_SHIFT + 1,
    localparam int FLD_W = PFN_W + 4
)(
    input  logic [WORD_W-1:0] tag,
    input  logic [WORD_W-1:0] tte,
    input  logic [WORD_W-1:0] va,
    input  logic [CTX_W-1:0]  ctx,
    output logic              match,
    output logic [FLD_W-1:0]  fld
);

    logic ctx_eq;
    logic page_eq;

    always_comb begin
        ctx_eq  = (tag[CTX_W-1:0] == ctx);
        page_eq = (((va[WORD_W-1:PAGE_SHIFT] ^ tag[WORD_W-1:PAGE_SHIFT])
                    & page_mask(tte[SZ_MSB:SZ_LSB])) == '0);
        match   = tte[VLD_BIT] & ctx_eq & page_eq;
        fld     = {tte[SZ_MSB:SZ_LSB], tte[PRIV_BIT], tte[WRT_BIT], tte[PA_MSB:PAGE_SHIFT]};
    end

    logic unused_bits;
    assign unused_bits = ^{va[PAGE_SHIFT-1:0], tte[SZ_LSB-1:PA_MSB+1],
                           tte[PAGE_SHIFT-1:PRIV_BIT+1], tte[0]};

endmodule

// File: rtl/tlb_xl_prio_pick.sv
module tlb_xl_prio_pick #(
    parameter int N = 64,
    parameter int W = 32
)(
    input  logic [N-1:0]   hit_vec,
    input  logic [N*W-1:0] fld_vec,
    output logic           any,
    output logic [W-1:0]   pick
);

    // scanning downward leaves the lowest matching index in place
    always_comb begin
        any  = |hit_vec;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                pick = fld_vec[i*W +: W];
            end
        end
    end

endmodule

// File: rtl/tlb_xl_status.sv
module tlb_xl_status
    import tlb_xl_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter bit IS_DATA = 1'b1
)(
    input  logic [STAT_W-1:0] cur,
    input  logic              user,
    input  logic              write,
    input  logic              priv,
    output logic [STAT_W-1:0] nxt
);

    logic [STAT_W-1:0] base;
    logic [STAT_W-1:0] fields;

    always_comb begin
        base   = cur[0] ? STAT_W'(OVF_CODE) : cur;
        fields = '0;
        fields[0]           = 1'b1;
        fields[ST_USER_BIT] = user;
        if (IS_DATA) begin
            fields[ST_WR_BIT]   = write;
            fields[ST_TYPE_LSB] = priv;
        end
        nxt = base | fields;
    end

    logic unused_in;
    assign unused_in = write ^ priv;

endmodule

// File: rtl/tlb_xlate_lookup.sv
module tlb_xlate_lookup
    import tlb_xl_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PA_MSB  = 40,
    parameter int STAT_W  = 16,
    parameter bit IS_DATA = 1'b1
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [63:0]               req_va,
    input  logic [12:0]               req_ctx,
    input  logic                      req_user,
    input  logic                      req_write,
    input  logic                      stat_clr,
    input  logic [ENTRIES*64-1:0]     tag_words,
    input  logic [ENTRIES*64-1:0]     tte_words,
    output logic                      busy,
    output logic                      hit,
    output logic                      miss,
    output logic                      fault,
    output logic [PA_MSB:0]           pa,
    output logic                      wr_ok,
    output logic [STAT_W-1:0]         fault_status,
    output logic [63:0]               fault_addr,
    output logic [63:0]               tag_access
);

    localparam int PFN_W = PA_MSB - PAGE_SHIFT + 1;
    localparam int FLD_W = PFN_W + 4;

    tlb_state_e state_q, state_d;

    logic [WORD_W-1:0]       q_va;
    logic [CTX_W-1:0]        q_ctx;
    logic                    q_user;
    logic                    q_write;

    logic [ENTRIES-1:0]       hit_vec;
    logic [ENTRIES*FLD_W-1:0] fld_vec;
    logic                     sel_any;
    logic [FLD_W-1:0]         sel_fld;
    logic                     r_any;
    logic [FLD_W-1:0]         r_fld;

    // ---------------- parallel compare ----------------
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_xl_entry_cmp #(.PA_MSB(PA_MSB)) u_cmp (
            .tag   (tag_words[g*WORD_W +: WORD_W]),
            .tte   (tte_words[g*WORD_W +: WORD_W]),
            .va    (q_va),
            .ctx   (q_ctx),
            .match (hit_vec[g]),
            .fld   (fld_vec[g*FLD_W +: FLD_W])
        );
    end

    tlb_xl_prio_pick #(.N(ENTRIES), .W(FLD_W)) u_pick (
        .hit_vec (hit_vec),
        .fld_vec (fld_vec),
        .any     (sel_any),
        .pick    (sel_fld)
    );

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // request capture and winner registration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_va    <= '0;
            q_ctx   <= '0;
            q_user  <= 1'b0;
            q_write <= 1'b0;
            r_any   <= 1'b0;
            r_fld   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                q_va    <= req_va;
                q_ctx   <= req_ctx;
                q_user  <= req_user;
                q_write <= req_write;
            end
            if (state_q == ST_LOOKUP) begin
                r_any <= sel_any;
                r_fld <= sel_fld;
            end
        end
    end

    // ---------------- resolve ----------------
    logic [1:0]        r_size;
    logic              r_priv;
    logic              r_wrt;
    logic [PFN_W-1:0]  r_pfn;
    logic [PFN_W-1:0]  keep_va;
    logic [PFN_W-1:0]  phys_pfn;
    logic              priv_viol;
    logic              wrt_viol;
    logic              do_fault;
    logic [STAT_W-1:0] stat_nxt;

    assign {r_size, r_priv, r_wrt, r_pfn} = r_fld;

    always_comb begin
        keep_va   = (PFN_W'(1) << (SIZE_STEP * int'(r_size))) - PFN_W'(1);
        phys_pfn  = (r_pfn & ~keep_va) | (q_va[PA_MSB:PAGE_SHIFT] & keep_va);
        priv_viol = r_priv & q_user;
        wrt_viol  = IS_DATA & ~r_wrt & q_write;
        do_fault  = (state_q == ST_RESOLVE) & r_any & (priv_viol | wrt_viol);
    end

    tlb_xl_status #(.STAT_W(STAT_W), .IS_DATA(IS_DATA)) u_stat (
        .cur   (fault_status),
        .user  (q_user),
        .write (q_write),
        .priv  (priv_viol),
        .nxt   (stat_nxt)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit          <= 1'b0;
            miss         <= 1'b0;
            fault        <= 1'b0;
            pa           <= '0;
            wr_ok        <= 1'b0;
            fault_status <= '0;
            fault_addr   <= '0;
            tag_access   <= '0;
        end else begin
            hit   <= 1'b0;
            miss  <= 1'b0;
            fault <= 1'b0;
            if (state_q == ST_RESOLVE) begin
                if (!r_any) begin
                    miss       <= 1'b1;
                    tag_access <= {q_va[WORD_W-1:PAGE_SHIFT], q_ctx};
                    pa         <= '0;
                    wr_ok      <= 1'b0;
                end else if (do_fault) begin
                    fault        <= 1'b1;
                    pa           <= '0;
                    wr_ok        <= 1'b0;
                    fault_status <= stat_nxt;
                    if (IS_DATA) begin
                        fault_addr <= q_va;
                    end
                end else begin
                    hit   <= 1'b1;
                    pa    <= {phys_pfn, {PAGE_SHIFT{1'b0}}};
                    wr_ok <= r_wrt;
                end
            end
            if (stat_clr && !do_fault) begin
                fault_status <= '0;
                fault_addr   <= '0;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss, fault})); // R12
    AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R12
    AST_OUTCOME_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss || fault) |-> ($past(state_q) == ST_RESOLVE)); // R2
    AST_FAULT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_status[0]); // R8
    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault_status[0])) |-> fault_status[1]); // R9
    AST_MISS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (tag_access[CTX_W-1:0] == q_ctx)); // R10
    AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !$past(stat_clr)) |-> $stable(fault_status)); // R10
    AST_WROK_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (miss || fault) |-> !wr_ok); // R7

endmodule

// File: tb/tb_tlb_xlate_lookup.sv
module tb_tlb_xlate_lookup;

    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [63:0] req_va    = '0;
    logic [12:0] req_ctx   = '0;
    logic        req_user  = 1'b0;
    logic        req_write = 1'b0;
    logic        stat_clr  = 1'b0;

    logic [63:0] tg [N];
    logic [63:0] tt [N];
    logic [N*64-1:0] tag_bus, tte_bus;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tag_bus[i*64 +: 64] = tg[i];
            tte_bus[i*64 +: 64] = tt[i];
        end
    end

    logic        busy, hit, miss, fault, wr_ok;
    logic [40:0] pa;
    logic [15:0] sfs;
    logic [63:0] sfa, tacc;

    logic        busy_i, hit_i, miss_i, fault_i, wr_ok_i;
    logic [40:0] pa_i;
    logic [15:0] sfs_i;
    logic [63:0] sfa_i, tacc_i;

    tlb_xlate_lookup #(.IS_DATA(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ctx(req_ctx), .req_user(req_user), .req_write(req_write),
        .stat_clr(stat_clr), .tag_words(tag_bus), .tte_words(tte_bus),
        .busy(busy), .hit(hit), .miss(miss), .fault(fault), .pa(pa),
        .wr_ok(wr_ok), .fault_status(sfs), .fault_addr(sfa), .tag_access(tacc)
    );

    tlb_xlate_lookup #(.IS_DATA(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ctx(req_ctx), .req_user(req_user), .req_write(req_write),
        .stat_clr(stat_clr), .tag_words(tag_bus), .tte_words(tte_bus),
        .busy(busy_i), .hit(hit_i), .miss(miss_i), .fault(fault_i), .pa(pa_i),
        .wr_ok(wr_ok_i), .fault_status(sfs_i), .fault_addr(sfa_i), .tag_access(tacc_i)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic logic [63:0] ref_mask(input logic [1:0] code);
        return 64'hFFFF_FFFF_FFFF_E000 << (3 * int'(code));
    endfunction

    function automatic int ref_find(input logic [63:0] va, input logic [12:0] ctx);
        for (int i = 0; i < N; i++) begin
            logic [63:0] m;
            m = ref_mask(tt[i][62:61]);
            if (tt[i][63] && tg[i][12:0] == ctx && ((va & m) == (tg[i] & m)))
                return i;
        end
        return -1;
    endfunction

    int          m_stage = 0;
    logic [63:0] m_va = '0;
    logic [12:0] m_ctx = '0;
    logic        m_user = 1'b0, m_wr = 1'b0;
    logic        e_hit = 1'b0, e_miss = 1'b0, e_fault = 1'b0, e_wrok = 1'b0;
    logic [40:0] e_pa = '0;
    logic [15:0] e_sfs = '0;
    logic [63:0] e_sfa = '0, e_tacc = '0;
    logic        m_faulted;
    logic        started = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_wrok = 0;
            e_pa = '0; e_sfs = '0; e_sfa = '0; e_tacc = '0;
        end else begin
            int idx;
            logic [63:0] t, m, full;
            logic pv, wv;
            m_faulted = 1'b0;
            e_hit = 0; e_miss = 0; e_fault = 0;
            if (m_stage == 2) begin
                idx = ref_find(m_va, m_ctx);
                if (idx < 0) begin
                    e_miss = 1; e_tacc = {m_va[63:13], m_ctx}; e_pa = '0; e_wrok = 0;
                end else begin
                    t  = tt[idx];
                    pv = t[2] && m_user;
                    wv = !t[1] && m_wr;
                    if (pv || wv) begin
                        e_fault = 1; m_faulted = 1'b1; e_pa = '0; e_wrok = 0;
                        if (e_sfs[0]) e_sfs = 16'h0002;
                        e_sfs = e_sfs | 16'h0001 | (16'(m_user) << 3) | (16'(m_wr) << 2) | (16'(pv) << 7);
                        e_sfa = m_va;
                    end else begin
                        m = ref_mask(t[62:61]);
                        full = ((t & m) | (m_va & ~m)) & 64'h0000_01FF_FFFF_E000;
                        e_hit = 1; e_pa = full[40:0]; e_wrok = t[1];
                    end
                end
                m_stage = 0;
            end else if (m_stage == 1) begin
                m_stage = 2;
            end else if (req_valid) begin
                m_va = req_va; m_ctx = req_ctx; m_user = req_user; m_wr = req_write;
                m_stage = 1;
            end
            if (stat_clr && !m_faulted) begin
                e_sfs = '0; e_sfa = '0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && started) begin
            chk("R2 hit (model)",          hit,   e_hit);
            chk("R10 miss (model)",        miss,  e_miss);
            chk("R6 fault (model)",        fault, e_fault);
            chk("R4 pa (model)",           pa,    e_pa);
            chk("R7 wr_ok (model)",        wr_ok, e_wrok);
            chk("R8 fault_status (model)", sfs,   e_sfs);
            chk("R8 fault_addr (model)",   sfa,   e_sfa);
            chk("R10 tag_access (model)",  tacc,  e_tacc);
            chk("R12 busy (model)",        busy,  m_stage != 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_req(input logic [63:0] va, input logic [12:0] ctx,
                          input logic u, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_ctx = ctx; req_user = u; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R12 watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] keep_tacc;
        for (int i = 0; i < N; i++) begin
            tg[i] = '0;
            tt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 hit",   hit,  0);
        chk("R1 miss",  miss, 0);
        chk("R1 fault", fault, 0);
        chk("R1 busy",  busy, 0);
        chk("R1 pa",    pa,   0);
        chk("R1 status", sfs, 0);
        chk("R1 fault_addr", sfa, 0);
        chk("R1 tag_access", tacc, 0);
        started = 1'b1;

        // R10 miss on empty buffer
        do_req(64'h0000_1234_5678_9ABC, 13'h0AB, 1'b1, 1'b0);
        chk("R10 miss pulse", miss, 1);
        chk("R10 tag_access", tacc, 64'h0000_1234_5678_80AB);
        chk("R10 status unchanged", sfs, 0);

        // R2 / R4 basic 8 KiB hit
        tg[5] = 64'h0000_1234_5678_8000 | 64'h0AB;
        tt[5] = 64'h8000_0000_0000_0000 | 64'h1_2345_6000 | 64'h2;
        do_req(64'h0000_1234_5678_9ABC, 13'h0AB, 1'b1, 1'b0);
        chk("R2 hit pulse", hit, 1);
        chk("R4 pa 8K", pa, 41'h1_2345_6000);
        chk("R7 wr_ok writable", wr_ok, 1);
        @(negedge clk);
        chk("R12 hit is one cycle", hit, 0);

        // R2 context mismatch
        do_req(64'h0000_1234_5678_9ABC, 13'h0AC, 1'b1, 1'b0);
        chk("R2 ctx mismatch miss", miss, 1);
        chk("R10 tag_access ctx", tacc, 64'h0000_1234_5678_80AC);

        // R3 page size codes
        tg[9] = 64'h4000_0000 | 64'h7;
        tt[9] = 64'h8000_0000_0000_0000 | (64'h3 << 61) | 64'h1540_0000;
        do_req(64'h4012_3456, 13'h7, 1'b0, 1'b0);
        chk("R3 4M hit", hit, 1);
        chk("R3 R4 4M pa", pa, 41'h1552_2000);
        chk("R7 wr_ok read-only", wr_ok, 0);
        tg[12] = 64'h7_0000 | 64'h7;
        tt[12] = 64'h8000_0000_0000_0000 | (64'h1 << 61) | 64'h3_0000_0000 | 64'h2;
        do_req(64'h7_E123, 13'h7, 1'b0, 1'b0);
        chk("R3 64K hit", hit, 1);
        chk("R3 64K pa", pa, 41'h3_0000_E000);
        do_req(64'h8_0123, 13'h7, 1'b0, 1'b0);
        chk("R3 outside 64K miss", miss, 1);

        // R5 lowest index wins
        tg[2]  = 64'h0000_00AA_0000_0000 | 64'h15;
        tt[2]  = 64'h8000_0000_0000_0000 | 64'hA000 | 64'h2;
        tg[11] = tg[2];
        tt[11] = 64'h8000_0000_0000_0000 | 64'hC000 | 64'h2;
        do_req(64'h0000_00AA_0000_1000, 13'h15, 1'b0, 1'b0);
        chk("R5 lowest index pa", pa, 41'hA000);

        // R6 / R8 privilege fault
        tg[20] = 64'h50_0000 | 64'h3;
        tt[20] = 64'h8000_0000_0000_0000 | 64'h2000 | 64'h4 | 64'h2;
        do_req(64'h50_0010, 13'h3, 1'b1, 1'b0);
        chk("R6 fault pulse", fault, 1);
        chk("R6 no hit", hit, 0);
        chk("R8 status priv", sfs, 16'h0089);
        chk("R8 fault_addr", sfa, 64'h50_0010);
        chk("R13 instr side also faults", fault_i, 1);

        // R7 / R9 write fault on top of a pending one
        tg[21] = 64'h60_0000 | 64'h3;
        tt[21] = 64'h8000_0000_0000_0000 | 64'h4000;
        do_req(64'h60_0008, 13'h3, 1'b0, 1'b1);
        chk("R7 write fault", fault, 1);
        chk("R9 overflow status", sfs, 16'h0007);
        chk("R8 fault_addr update", sfa, 64'h60_0008);

        // R11 clear
        pulse_clr();
        chk("R11 status cleared", sfs, 0);
        chk("R11 fault_addr cleared", sfa, 0);
        do_req(64'h60_0008, 13'h3, 1'b0, 1'b1);
        chk("R9 no overflow after clear", sfs, 16'h0005);
        chk("R13 instr side write allowed", hit_i, 1);
        chk("R13 instr wr_ok", wr_ok_i, 0);

        // R7 write to writable page
        do_req(64'h0000_1234_5678_9ABC, 13'h0AB, 1'b1, 1'b1);
        chk("R7 write hit", hit, 1);
        chk("R7 write wr_ok", wr_ok, 1);

        // R2 valid bit cleared
        tt[5] = tt[5] & ~(64'h1 << 63);
        do_req(64'h0000_1234_5678_9ABC, 13'h0AB, 1'b1, 1'b0);
        chk("R2 invalid entry misses", miss, 1);

        // R12 request while busy is ignored
        keep_tacc = tacc;
        @(negedge clk);
        req_valid = 1'b1; req_va = 64'h7_0100; req_ctx = 13'h7; req_user = 0; req_write = 0;
        @(negedge clk);
        chk("R12 busy after accept", busy, 1);
        req_va = 64'hDEAD_0000; req_ctx = 13'h1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R12 first request served", hit, 1);
        chk("R12 first request pa", pa, 41'h3_0000_0000);
        repeat (3) @(negedge clk);
        chk("R12 second request dropped", tacc, keep_tacc);
        chk("R12 idle again", busy, 0);

        // R13 instruction variant status
        pulse_clr();
        do_req(64'h50_0010, 13'h3, 1'b1, 1'b0);
        chk("R13 instr fault", fault_i, 1);
        chk("R13 instr status", sfs_i, 16'h0009);
        chk("R13 instr fault_addr untouched", sfa_i, 0);
        chk("R8 data status after clear", sfs, 16'h0089);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule